// File: doc/BRIEF.md
# Differential Synapse Delta-Rule Update Sequencer

This block runs one error-driven learning step over an array of synapses, where each synapse is held as a pair of conductance devices whose difference forms the weight. When a start request arrives, it compares the absolute gap between the network's prediction and the target against a threshold. The step goes ahead only if the pre-synaptic spike flag is also set. It then walks every pair in the array.

For each pair the block:
- issues a read and waits for the two returned current codes;
- scales those codes by two fixed-point constants;
- moves the two scaled values in opposite directions by the learning rate times the error, with the direction set by the sign of the prediction error;
- converts both adjusted states into compliance-current codes;
- rewrites the pair with a reset command followed by a set command.

All arithmetic is signed Q8.8 (16 bits, 8 fractional bits). Products are rounded by adding half an LSB and truncating toward minus infinity. Every result saturates at the format limits instead of wrapping. The device side is a valid/ready command port plus a separate response strobe.

Top module: `dm_delta_seq`

## Requirements
- R1: A pass starts only when `start_i` and `pre_spike_i` are both high and the error magnitude |pred - tgt| (saturated to 0x7FFF) is strictly greater than the signed threshold. Otherwise no command is issued and `busy_o` stays low.
- R2: A pass visits pair indices 0 to NPAIRS-1 in ascending order. For each pair it issues READ (op 0), then RESET (op 1), then SET (op 2), and a new command appears only after the previous one was accepted with `cmd_valid_o && cmd_ready_i`. After a READ is accepted, no command is offered until `rsp_valid_i` has been seen.
- R3: The currents on `rsp_cur1_i` and `rsp_cur2_i` are captured when `rsp_valid_i` is high after a READ. The scaled currents are I1 = round(cur1*c1) and I2 = round(cur2*c2), in Q8.8 with saturation.
- R4: When pred - tgt > 0, S1 = sat(I1 + E) and S2 = sat(I2 - E), where E = round(eta*|pred - tgt|).
- R5: When pred - tgt <= 0, including zero, S1 = sat(I1 - E) and S2 = sat(I2 + E).
- R6: `cmd_icc1_o` = round(S1*c2) and `cmd_icc2_o` = round(S2*c2), with the same constant c2 for both devices. RESET and SET for a pair carry identical codes, and READ carries zero codes.
- R7: While `cmd_valid_o` is high and `cmd_ready_i` is low, the opcode, index and both codes hold steady.
- R8: `busy_o` rises in the cycle after an accepted start and falls when `done_o` pulses. `done_o` is a one-cycle pulse in the cycle after the final SET is accepted.
- R9: A start request while busy is ignored. Operands (pred, tgt, eta, c1, c2) are sampled at the accepted start, and later changes on those inputs have no effect within the pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one update pass |
| pre_spike_i | input | 1 | Pre-synaptic spike flag |
| pred_i | input | 16 | Predicted output, Q8.8 |
| tgt_i | input | 16 | Target output, Q8.8 |
| thresh_i | input | 16 | Error threshold, signed Q8.8 |
| eta_i | input | 16 | Learning rate, Q8.8 |
| c1_i | input | 16 | Scale for first current, Q8.8 |
| c2_i | input | 16 | Scale for second current and compliance, Q8.8 |
| cmd_valid_o | output | 1 | Command offered |
| cmd_ready_i | input | 1 | Device accepts command |
| cmd_op_o | output | 2 | 0 READ, 1 RESET, 2 SET |
| cmd_idx_o | output | 10 | Pair index |
| cmd_icc1_o | output | 16 | Compliance code, first device |
| cmd_icc2_o | output | 16 | Compliance code, second device |
| rsp_valid_i | input | 1 | Read response strobe |
| rsp_cur1_i | input | 16 | Read current, first device |
| rsp_cur2_i | input | 16 | Read current, second device |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle pass completion pulse |

## Verification
The hardest situation to reach from the ports is the one where the saturation boundaries combine. A clipped error magnitude feeds an eta product, which is then added to an already clipped scaled current, which is clipped again when multiplied by c2. The bench sweeps error cases against learning rates and constant pairs, including a negative c1 and near-full-scale currents from its device model, to reach these boundaries. Each pass also fires a stray start with scrambled operands while the first response is still pending, so the latching is visible in the codes of every later pair.

// File: rtl/dm_delta_pkg.sv
package dm_delta_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_RESET = 2'd1,
    OP_SET   = 2'd2
  } dm_op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WAIT = 3'd2,
    ST_RST  = 3'd3,
    ST_SET  = 3'd4
  } dm_state_e;
endpackage

// File: rtl/dm_fx_mul.sv
module dm_fx_mul #(
  parameter int DW = 16,
  parameter int FW = 8
) (
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  output logic signed [DW-1:0] y_o
);
  localparam int PW = 2 * DW;
  localparam logic signed [PW-1:0] HALF = {{(PW-1){1'b0}}, 1'b1} << (FW - 1);
  localparam logic signed [PW-1:0] MAXV = {{(DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rnd;

  always_comb begin
    prod = PW'(a_i) * PW'(b_i);
    rnd  = (prod + HALF) >>> FW;
    if (rnd > MAXV)      y_o = MAXV[DW-1:0];
    else if (rnd < MINV) y_o = MINV[DW-1:0];
    else                 y_o = rnd[DW-1:0];
  end
endmodule

// File: rtl/dm_fx_addsat.sv
module dm_fx_addsat #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  logic                 sub_i,
  output logic signed [DW-1:0] y_o
);
  logic signed [DW:0] sum;

  always_comb begin
    if (sub_i) sum = {a_i[DW-1], a_i} - {b_i[DW-1], b_i};
    else       sum = {a_i[DW-1], a_i} + {b_i[DW-1], b_i};
    if (sum[DW] != sum[DW-1]) y_o = {sum[DW], {(DW-1){~sum[DW]}}};
    else                      y_o = sum[DW-1:0];
  end
endmodule

// File: rtl/dm_pair_calc.sv
module dm_pair_calc #(
  parameter int DW = 16,
  parameter int FW = 8
) (
  input  logic signed [DW-1:0] cur1_i,
  input  logic signed [DW-1:0] cur2_i,
  input  logic signed [DW-1:0] c1_i,
  input  logic signed [DW-1:0] c2_i,
  input  logic signed [DW-1:0] step_i,
  input  logic                 pos_i,
  output logic signed [DW-1:0] icc1_o,
  output logic signed [DW-1:0] icc2_o
);
  localparam int LANES = 2;

  logic signed [DW-1:0] cur   [LANES];
  logic signed [DW-1:0] scl_k [LANES];
  logic signed [DW-1:0] scl   [LANES];
  logic signed [DW-1:0] st    [LANES];
  logic signed [DW-1:0] icc   [LANES];
  logic                 lsub  [LANES];

  assign cur[0]   = cur1_i;
  assign cur[1]   = cur2_i;
  assign scl_k[0] = c1_i;
  assign scl_k[1] = c2_i;
  assign lsub[0]  = ~pos_i;
  assign lsub[1]  = pos_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dm_fx_mul #(.DW(DW), .FW(FW)) u_scale (
      .a_i(cur[g]), .b_i(scl_k[g]), .y_o(scl[g]));
    dm_fx_addsat #(.DW(DW)) u_adj (
      .a_i(scl[g]), .b_i(step_i), .sub_i(lsub[g]), .y_o(st[g]));
    dm_fx_mul #(.DW(DW), .FW(FW)) u_icc (
      .a_i(st[g]), .b_i(c2_i), .y_o(icc[g]));
  end

  assign icc1_o = icc[0];
  assign icc2_o = icc[1];
endmodule

// File: rtl/dm_delta_ctrl.sv
module dm_delta_ctrl
  import dm_delta_pkg::*;
#(
  parameter int NPAIRS = 8,
  parameter int IW     = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic          cmd_ready_i,
  input  logic          rsp_valid_i,
  output logic          idle_o,
  output logic          cmd_valid_o,
  output dm_op_e        op_o,
  output logic [IW-1:0] idx_o,
  output logic          cap_en_o,
  output logic          done_o
);
  localparam logic [IW-1:0] LAST = IW'(NPAIRS - 1);

  dm_state_e     state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          done_q, done_d;
  logic          st_en, idx_en;
  logic          hs;

  assign hs = cmd_valid_o & cmd_ready_i;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: if (go_i) begin state_d = ST_RD; idx_d = '0; end
      ST_RD:   if (hs) state_d = ST_WAIT;
      ST_WAIT: if (rsp_valid_i) state_d = ST_RST;
      ST_RST:  if (hs) state_d = ST_SET;
      ST_SET:  if (hs) begin
                 if (idx_q == LAST) begin state_d = ST_IDLE; done_d = 1'b1; end
                 else begin state_d = ST_RD; idx_d = idx_q + 1'b1; end
               end
      default: state_d = ST_IDLE;
    endcase
  end

  assign st_en  = (state_d != state_q);
  assign idx_en = (idx_d != idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      if (st_en)  state_q <= state_d;
      if (idx_en) idx_q   <= idx_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    idle_o      = (state_q == ST_IDLE);
    cmd_valid_o = (state_q == ST_RD) || (state_q == ST_RST) || (state_q == ST_SET);
    cap_en_o    = (state_q == ST_WAIT) && rsp_valid_i;
    case (state_q)
      ST_RST:  op_o = OP_RESET;
      ST_SET:  op_o = OP_SET;
      default: op_o = OP_READ;
    endcase
  end

  assign idx_o  = idx_q;
  assign done_o = done_q;
endmodule

// File: rtl/dm_delta_seq.sv
module dm_delta_seq
  import dm_delta_pkg::*;
#(
  parameter int DW     = 16,
  parameter int FW     = 8,
  parameter int IW     = 10,
  parameter int NPAIRS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          pre_spike_i,
  input  logic [DW-1:0] pred_i,
  input  logic [DW-1:0] tgt_i,
  input  logic [DW-1:0] thresh_i,
  input  logic [DW-1:0] eta_i,
  input  logic [DW-1:0] c1_i,
  input  logic [DW-1:0] c2_i,
  output logic          cmd_valid_o,
  input  logic          cmd_ready_i,
  output logic [1:0]    cmd_op_o,
  output logic [IW-1:0] cmd_idx_o,
  output logic [DW-1:0] cmd_icc1_o,
  output logic [DW-1:0] cmd_icc2_o,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_cur1_i,
  input  logic [DW-1:0] rsp_cur2_i,
  output logic          busy_o,
  output logic          done_o
);
  localparam logic [DW-1:0] MAXPOS = {1'b0, {(DW-1){1'b1}}};

  logic signed [DW:0]   diff;
  logic        [DW:0]   mag;
  logic        [DW-1:0] mag_sat;
  logic                 over_th, go, idle, cap_en;
  logic signed [DW-1:0] step_c;
  logic signed [DW-1:0] step_q, c1_q, c2_q, cur1_q, cur2_q;
  logic                 pos_q;
  logic signed [DW-1:0] icc1, icc2;
  dm_op_e               op;

  always_comb begin
    diff    = $signed({pred_i[DW-1], pred_i}) - $signed({tgt_i[DW-1], tgt_i});
    mag     = diff[DW] ? -diff : diff;
    mag_sat = (mag[DW:DW-1] != 2'b00) ? MAXPOS : mag[DW-1:0];
    over_th = $signed({1'b0, mag_sat}) > $signed({thresh_i[DW-1], thresh_i});
  end

  assign go = start_i & pre_spike_i & over_th & idle;

  dm_fx_mul #(.DW(DW), .FW(FW)) u_step (
    .a_i($signed(eta_i)), .b_i($signed(mag_sat)), .y_o(step_c));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      c1_q   <= '0;
      c2_q   <= '0;
      pos_q  <= 1'b0;
    end else if (go) begin
      step_q <= step_c;
      c1_q   <= $signed(c1_i);
      c2_q   <= $signed(c2_i);
      pos_q  <= (diff > 0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur1_q <= '0;
      cur2_q <= '0;
    end else if (cap_en) begin
      cur1_q <= $signed(rsp_cur1_i);
      cur2_q <= $signed(rsp_cur2_i);
    end
  end

  dm_delta_ctrl #(.NPAIRS(NPAIRS), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go_i(go), .cmd_ready_i(cmd_ready_i),
    .rsp_valid_i(rsp_valid_i), .idle_o(idle), .cmd_valid_o(cmd_valid_o),
    .op_o(op), .idx_o(cmd_idx_o), .cap_en_o(cap_en), .done_o(done_o));

  dm_pair_calc #(.DW(DW), .FW(FW)) u_calc (
    .cur1_i(cur1_q), .cur2_i(cur2_q), .c1_i(c1_q), .c2_i(c2_q),
    .step_i(step_q), .pos_i(pos_q), .icc1_o(icc1), .icc2_o(icc2));

  assign cmd_op_o   = op;
  assign cmd_icc1_o = (op == OP_READ) ? '0 : icc1;
  assign cmd_icc2_o = (op == OP_READ) ? '0 : icc2;
  assign busy_o     = ~idle;
endmodule

// File: rtl/dm_delta_chk.sv
module dm_delta_chk #(
  parameter int DW = 16,
  parameter int IW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          cmd_valid_o,
  input logic          cmd_ready_i,
  input logic [1:0]    cmd_op_o,
  input logic [IW-1:0] cmd_idx_o,
  input logic [DW-1:0] cmd_icc1_o,
  input logic [DW-1:0] cmd_icc2_o,
  input logic          busy_o,
  input logic          done_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !cmd_valid_o);

  assert_read_waits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_ready_i && cmd_op_o == 2'd0) |=> !cmd_valid_o);

  assert_reset_then_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_ready_i && cmd_op_o == 2'd1) |=>
      (cmd_valid_o && cmd_op_o == 2'd2 && $stable(cmd_idx_o)));

  assert_next_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_ready_i && cmd_op_o == 2'd2) |=>
      (done_o || (cmd_valid_o && cmd_op_o == 2'd0 && cmd_idx_o == $past(cmd_idx_o) + 1'b1)));

  assert_same_codes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_ready_i && cmd_op_o == 2'd1) |=>
      ($stable(cmd_icc1_o) && $stable(cmd_icc2_o)));

  assert_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_op_o == 2'd0) |-> (cmd_icc1_o == '0 && cmd_icc2_o == '0));

  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_idx_o) &&
       $stable(cmd_icc1_o) && $stable(cmd_icc2_o)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_busy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind dm_delta_seq dm_delta_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_valid_o(cmd_valid_o),
  .cmd_ready_i(cmd_ready_i), .cmd_op_o(cmd_op_o), .cmd_idx_o(cmd_idx_o),
  .cmd_icc1_o(cmd_icc1_o), .cmd_icc2_o(cmd_icc2_o), .busy_o(busy_o),
  .done_o(done_o));

// File: tb/dm_delta_seq_tb.sv
module dm_delta_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;

  logic clk, rst_n;
  logic start_i, pre_spike_i, cmd_ready_i, rsp_valid_i;
  logic [15:0] pred_i, tgt_i, thresh_i, eta_i, c1_i, c2_i, rsp_cur1_i, rsp_cur2_i;
  logic cmd_valid_o, busy_o, done_o;
  logic [1:0] cmd_op_o;
  logic [9:0] cmd_idx_o;
  logic [15:0] cmd_icc1_o, cmd_icc2_o;

  int nvec = 0, nbad = 0, cyc = 0, pass_no = 0;

  dm_delta_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pre_spike_i(pre_spike_i),
    .pred_i(pred_i), .tgt_i(tgt_i), .thresh_i(thresh_i), .eta_i(eta_i),
    .c1_i(c1_i), .c2_i(c2_i), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
    .cmd_op_o(cmd_op_o), .cmd_idx_o(cmd_idx_o), .cmd_icc1_o(cmd_icc1_o),
    .cmd_icc2_o(cmd_icc2_o), .rsp_valid_i(rsp_valid_i), .rsp_cur1_i(rsp_cur1_i),
    .rsp_cur2_i(rsp_cur2_i), .busy_o(busy_o), .done_o(done_o));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nbad++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  function automatic int sat(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int rmul(int a, int b);
    return sat((a * b + 128) >>> 8);
  endfunction

  function automatic int sx(logic [15:0] v);
    return int'($signed(v));
  endfunction

  function automatic logic [15:0] cv(int k);
    case (k % 8)
      0: return 16'h0100;
      1: return 16'hFD80;
      2: return 16'h7F00;
      3: return 16'h8000;
      4: return 16'h0033;
      5: return 16'hFFFF;
      6: return 16'h1234;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic get_cmd(int op, int idx, int e1, int e2, int stall, string req);
    int st = stall;
    while (!(cmd_valid_o && st == 0)) begin
      if (cmd_valid_o) st--;
      @(negedge clk);
    end
    cmd_ready_i = 1'b1;
    chk(cmd_op_o == 2'(op), "R2 opcode", int'(cmd_op_o), op);
    chk(cmd_idx_o == 10'(idx), "R2 index", int'(cmd_idx_o), idx);
    chk(sx(cmd_icc1_o) == e1, req, sx(cmd_icc1_o), e1);
    chk(sx(cmd_icc2_o) == e2, req, sx(cmd_icc2_o), e2);
    chk(busy_o == 1'b1, "R8 busy during pass", int'(busy_o), 1);
    @(negedge clk);
    cmd_ready_i = 1'b0;
  endtask

  task automatic run_pass(int pr, int tg, int th, int et, int k1, int k2, bit spk);
    int d = pr - tg;
    int err = sat(d < 0 ? -d : d);
    bit gate = spk && (err > th);
    bit pos = d > 0;
    int step = rmul(et, err);
    string rq = pos ? "R4/R6 codes (positive error)" : "R5/R6 codes (non-positive error)";
    pass_no++;
    pred_i = 16'(pr); tgt_i = 16'(tg); thresh_i = 16'(th);
    eta_i = 16'(et); c1_i = 16'(k1); c2_i = 16'(k2); pre_spike_i = spk;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    pred_i = ~pred_i; tgt_i = 16'h0000; eta_i = 16'h0300; c1_i = 16'hFF00; c2_i = 16'h0001;
    if (!gate) begin
      for (int w = 0; w < 5; w++) begin
        chk(!cmd_valid_o && !busy_o && !done_o, "R1 gated pass stays quiet",
            int'({cmd_valid_o, busy_o, done_o}), 0);
        @(negedge clk);
      end
      return;
    end
    chk(busy_o == 1'b1, "R8 busy after start", int'(busy_o), 1);
    for (int i = 0; i < NP; i++) begin
      logic [15:0] r1 = cv(i * 3 + pass_no);
      logic [15:0] r2 = cv(i * 5 + pass_no + 3);
      int s1, s2;
      s1 = sat(rmul(sx(r1), k1) + (pos ? step : -step));
      s2 = sat(rmul(sx(r2), k2) + (pos ? -step : step));
      get_cmd(0, i, 0, 0, i % 2, "R6 read carries zero codes");
      if (i == 0) begin
        start_i = 1'b1; pre_spike_i = 1'b1; thresh_i = 16'h8000;
        @(negedge clk);
        start_i = 1'b0;
        chk(!cmd_valid_o, "R9 start while busy ignored", int'(cmd_valid_o), 0);
      end
      repeat (i % 3) @(negedge clk);
      rsp_valid_i = 1'b1; rsp_cur1_i = r1; rsp_cur2_i = r2;
      @(negedge clk);
      rsp_valid_i = 1'b0; rsp_cur1_i = 16'hDEAD; rsp_cur2_i = 16'hBEEF;
      get_cmd(1, i, rmul(s1, k2), rmul(s2, k2), (i + 1) % 3, {rq, " R3 reset"});
      get_cmd(2, i, rmul(s1, k2), rmul(s2, k2), i % 2, {rq, " R9 set"});
    end
    chk(done_o == 1'b1 && busy_o == 1'b0, "R8 done pulse", int'({done_o, busy_o}), 2);
    @(negedge clk);
    chk(done_o == 1'b0, "R8 done lasts one cycle", int'(done_o), 0);
  endtask

  initial begin
    int er_p[5], er_t[5], er_th[5];
    int etas[3];
    int ka[3], kb[3];
    er_p  = '{16'sh0300, -16'sh0080, 16'sh0050, 16'sh0200, 16'sh7F00};
    er_t  = '{16'sh0100, 16'sh0200, 16'sh0050, 16'sh0100, -16'sh7F00};
    er_th = '{16'sh0040, 16'sh0000, -1, 16'sh0100, 16'sh1000};
    etas  = '{16'sh0080, 16'sh0100, 16'sh0400};
    ka    = '{16'sh0100, 16'sh0180, -16'sh0100};
    kb    = '{16'sh0100, 16'sh0040, 16'sh0300};
    rst_n = 1'b0; start_i = 1'b0; pre_spike_i = 1'b0; cmd_ready_i = 1'b0;
    rsp_valid_i = 1'b0; pred_i = '0; tgt_i = '0; thresh_i = '0; eta_i = '0;
    c1_i = '0; c2_i = '0; rsp_cur1_i = '0; rsp_cur2_i = '0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !cmd_valid_o, "R8 reset state",
        int'({busy_o, done_o, cmd_valid_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_pass(16'sh0400, 16'sh0100, 16'sh0000, 16'sh0100, 16'sh0100, 16'sh0100, 1'b0);
    for (int e = 0; e < 5; e++)
      for (int a = 0; a < 3; a++)
        for (int c = 0; c < 3; c++)
          run_pass(er_p[e], er_t[e], er_th[e], etas[a], ka[c], kb[c], 1'b1);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule